// File: doc/BRIEF.md
# Bus-Attached GPIO Block with Port-A Interrupt Unit

This block is an APB slave that gives software up to four general-purpose I/O ports. Each port has a writable output value register and a writable drive-enable register, and both drive the pads directly. Each port also has a read-only register that returns the pad inputs after a two-stage synchroniser. Each port is up to 32 bits wide, and a parameter sets the width of each port. Bits above a port's width read as zero and drive zero.

Port A also has an interrupt unit. The unit has per-bit enables, masks, an edge/level select and a polarity select. Edge events latch until software writes a one to the matching bit of the clear register. A per-bit debounce filter can be switched into the port-A input path. The filter accepts a new input value only after that value has been seen on two consecutive strobes of a slow sampling enable. The block drives one interrupt line per port-A bit and one combined interrupt line. A build-time parameter moves five of the interrupt registers to an alternate offset map.

Top module: `apb_gpio_top`

## Requirements
- R1: After reset, every register reads zero, and `pin_out`, `pin_oe`, `irq_bits` and `irq` are all zero.
- R2: Port p has its output value register at byte offset 12·p and its drive-enable register at 12·p+4. Both are read/write. `pin_out` lane p carries the output value, and `pin_oe` lane p carries the drive enable (1 = drive). Bits at or above the port width read and drive 0.
- R3: Offset 0x50+4·p returns port p's pad inputs through two flops. A read whose access phase falls one cycle after a pad change still returns the old value. Writes to these offsets have no effect.
- R4: Type bit = 1 (offset 0x38) selects edge mode. Polarity bit = 1 (offset 0x3C) selects a rising edge and 0 selects a falling edge. A detected edge stays pending after the input returns to its old value.
- R5: Type bit = 0 selects level mode. The pending state follows the input, active high for polarity 1 and active low for polarity 0.
- R6: Status (offset 0x40) reads pending AND enable AND NOT mask. `irq_bits` equals status, and `irq` is the OR of its bits.
- R7: A mask bit of 1 (offset 0x34) hides that bit from status and from the outputs. Clearing the mask bit shows a still-latched edge again.
- R8: Writing ones to offset 0x4C clears those latched edges, and zero bits leave their latched edges pending. The register reads 0. An edge detected in the same cycle as its clear remains pending.
- R9: Edges are latched only while the bit's enable (offset 0x30) is 1. Enabling a bit later does not reveal an edge that occurred while it was disabled.
- R10: With debounce bit = 1 (offset 0x48), a port-A input change reaches the interrupt logic and the input register only after the new value is seen on two consecutive `db_tick` strobes. A pulse shorter than the strobe spacing is discarded.
- R11: With `ALT_MAP` = 1, mask is at 0x44, type at 0x34, polarity at 0x38, status at 0x3C and clear at 0x40, while enable and debounce keep their offsets. Offset 0x44 is unmapped (reads 0) when `ALT_MAP` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 7 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| db_tick | input | 1 | Debounce sampling strobe |
| pin_in | input | 32·NPORTS | Pad inputs, one 32-bit lane per port |
| pin_out | output | 32·NPORTS | Output values, one lane per port |
| pin_oe | output | 32·NPORTS | Drive enables, one lane per port |
| irq_bits | output | 32 | Per-bit port-A interrupts |
| irq | output | 1 | Combined interrupt |

## Verification
Two port-A functions can act on the same bit in one cycle: a software clear of a latched edge and the detection of a new edge. The bench sets up this collision by latching an edge on bit 0 and then returning the pad to its idle level. It then raises the pad exactly one negedge before starting a clear write, so that the write commits on the same edge where the synchronised input first differs from its previous sample. The bench expects the bit to remain pending afterwards. It then expects a second clear, made with no new edge, to remove the bit.

// File: rtl/apb_gpio_pkg.sv
package apb_gpio_pkg;

    localparam int unsigned LANE      = 32;
    localparam int unsigned MAX_PORTS = 4;
    localparam int unsigned ADDR_W    = 7;

    localparam logic [ADDR_W-1:0] PORT_STRIDE = 7'h0C;
    localparam logic [ADDR_W-1:0] DIR_OFS     = 7'h04;
    localparam logic [ADDR_W-1:0] EXT_BASE    = 7'h50;
    localparam logic [ADDR_W-1:0] EXT_STRIDE  = 7'h04;

    localparam logic [ADDR_W-1:0] OFS_IEN   = 7'h30;
    localparam logic [ADDR_W-1:0] OFS_DBEN  = 7'h48;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 7'h34;
    localparam logic [ADDR_W-1:0] OFS_TYPE  = 7'h38;
    localparam logic [ADDR_W-1:0] OFS_POL   = 7'h3C;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 7'h40;
    localparam logic [ADDR_W-1:0] OFS_EOI   = 7'h4C;
    localparam logic [ADDR_W-1:0] ALT_MASK  = 7'h44;
    localparam logic [ADDR_W-1:0] ALT_TYPE  = 7'h34;
    localparam logic [ADDR_W-1:0] ALT_POL   = 7'h38;
    localparam logic [ADDR_W-1:0] ALT_STAT  = 7'h3C;
    localparam logic [ADDR_W-1:0] ALT_EOI   = 7'h40;

    typedef enum logic [3:0] {
        K_NONE, K_DATA, K_DIR, K_EXT,
        K_IEN, K_IMASK, K_ITYPE, K_IPOL, K_ISTAT, K_DBEN, K_EOI
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] port;
    } reg_sel_t;

    function automatic logic [LANE-1:0] width_mask(input int unsigned w);
        if (w >= LANE) return '1;
        return {LANE{1'b1}} >> (LANE - w);
    endfunction

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a, input logic alt);
        reg_sel_t s;
        s.kind = K_NONE;
        s.port = 2'd0;
        for (int p = 0; p < MAX_PORTS; p++) begin
            if (a == ADDR_W'(p) * PORT_STRIDE) begin
                s.kind = K_DATA; s.port = 2'(p);
            end
            if (a == ADDR_W'(p) * PORT_STRIDE + DIR_OFS) begin
                s.kind = K_DIR; s.port = 2'(p);
            end
            if (a == EXT_BASE + ADDR_W'(p) * EXT_STRIDE) begin
                s.kind = K_EXT; s.port = 2'(p);
            end
        end
        if (a == OFS_IEN)       s.kind = K_IEN;
        else if (a == OFS_DBEN) s.kind = K_DBEN;
        else if (!alt) begin
            if (a == OFS_MASK)      s.kind = K_IMASK;
            else if (a == OFS_TYPE) s.kind = K_ITYPE;
            else if (a == OFS_POL)  s.kind = K_IPOL;
            else if (a == OFS_STAT) s.kind = K_ISTAT;
            else if (a == OFS_EOI)  s.kind = K_EOI;
        end else begin
            if (a == ALT_MASK)      s.kind = K_IMASK;
            else if (a == ALT_TYPE) s.kind = K_ITYPE;
            else if (a == ALT_POL)  s.kind = K_IPOL;
            else if (a == ALT_STAT) s.kind = K_ISTAT;
            else if (a == ALT_EOI)  s.kind = K_EOI;
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] last_q;
    logic [W-1:0] filt_q;

    // A bit is accepted when two consecutive strobe samples agree.
    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            filt_q <= '0;
        end else if (tick) begin
            last_q <= d;
            filt_q <= ((d ~^ last_q) & d) | ((d ^ last_q) & filt_q);
        end
    end

    assign q = (en & filt_q) | (~en & d);

    // R10: the filtered value only moves on a strobe
    p_db_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(filt_q));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import apb_gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LANE-1:0] lvl,
    input  logic            we,
    input  reg_kind_e       kind,
    input  logic [LANE-1:0] wdata,
    output logic [LANE-1:0] en_o,
    output logic [LANE-1:0] mask_o,
    output logic [LANE-1:0] typ_o,
    output logic [LANE-1:0] pol_o,
    output logic [LANE-1:0] status_o,
    output logic            irq_o
);
    localparam logic [LANE-1:0] VM = width_mask(WIDTH);

    logic [LANE-1:0] en_q, mask_q, typ_q, pol_q, prev_q, raw_edge_q;
    logic [LANE-1:0] ev, clr, level_hit, raw;

    assign ev  = en_q & typ_q & VM &
                 ((pol_q & lvl & ~prev_q) | (~pol_q & ~lvl & prev_q));
    assign clr = (we && kind == K_EOI) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= '0;
            mask_q     <= '0;
            typ_q      <= '0;
            pol_q      <= '0;
            prev_q     <= '0;
            raw_edge_q <= '0;
        end else begin
            if (we) begin
                case (kind)
                    K_IEN:   en_q   <= wdata & VM;
                    K_IMASK: mask_q <= wdata & VM;
                    K_ITYPE: typ_q  <= wdata & VM;
                    K_IPOL:  pol_q  <= wdata & VM;
                    default: ;
                endcase
            end
            prev_q     <= lvl;
            // a new edge wins over a clear in the same cycle
            raw_edge_q <= (raw_edge_q & ~clr) | ev;
        end
    end

    assign level_hit = ~(lvl ^ pol_q);
    assign raw       = (typ_q & raw_edge_q) | (~typ_q & level_hit);
    assign status_o  = raw & en_q & ~mask_q & VM;
    assign irq_o     = |status_o;
    assign en_o      = en_q;
    assign mask_o    = mask_q;
    assign typ_o     = typ_q;
    assign pol_o     = pol_q;

    // R4: a latched edge stays until cleared
    p_edge_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (|(raw_edge_q & ~clr)) |=>
            ((raw_edge_q & $past(raw_edge_q & ~clr)) == $past(raw_edge_q & ~clr)));

    // R8: a clear without a coincident edge removes the bit
    p_eoi_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (|(clr & ~ev)) |=> ((raw_edge_q & $past(clr & ~ev)) == '0));

    // R9: disabled, idle bits never latch
    p_off_no_latch_r9: assert property (@(posedge clk) disable iff (rst)
        (|(~en_q & ~raw_edge_q)) |=> ((raw_edge_q & $past(~en_q & ~raw_edge_q)) == '0));
endmodule

// File: rtl/apb_gpio_top.sv
module apb_gpio_top
    import apb_gpio_pkg::*;
#(
    parameter int unsigned NPORTS            = 4,
    parameter int unsigned PORT_W [MAX_PORTS] = '{8, 8, 8, 4},
    parameter bit          ALT_MAP           = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   psel,
    input  logic                   penable,
    input  logic                   pwrite,
    input  logic [ADDR_W-1:0]      paddr,
    input  logic [LANE-1:0]        pwdata,
    output logic [LANE-1:0]        prdata,
    output logic                   pready,
    input  logic                   db_tick,
    input  logic [NPORTS*LANE-1:0] pin_in,
    output logic [NPORTS*LANE-1:0] pin_out,
    output logic [NPORTS*LANE-1:0] pin_oe,
    output logic [LANE-1:0]        irq_bits,
    output logic                   irq
);
    localparam logic [LANE-1:0] VMA = width_mask(PORT_W[0]);

    reg_sel_t        sel;
    logic            wr_en;
    logic [LANE-1:0] dat_rd [MAX_PORTS];
    logic [LANE-1:0] dir_rd [MAX_PORTS];
    logic [LANE-1:0] ext_rd [MAX_PORTS];
    logic [LANE-1:0] dben_q, lvl_a;
    logic [LANE-1:0] ien_w, imask_w, itype_w, ipol_w, istat_w;
    logic [LANE-1:0] rdata;

    assign sel    = decode_addr(paddr, ALT_MAP);
    assign wr_en  = psel && penable && pwrite;
    assign pready = 1'b1;

    always_ff @(posedge clk) begin
        if (rst)                            dben_q <= '0;
        else if (wr_en && sel.kind == K_DBEN) dben_q <= pwdata & VMA;
    end

    for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
        if (p < NPORTS) begin : g_on
            localparam logic [LANE-1:0] VM = width_mask(PORT_W[p]);
            logic [LANE-1:0] dat_q, dir_q, syn;

            always_ff @(posedge clk) begin
                if (rst) begin
                    dat_q <= '0;
                    dir_q <= '0;
                end else if (wr_en && sel.port == 2'(p)) begin
                    if (sel.kind == K_DATA) dat_q <= pwdata & VM;
                    if (sel.kind == K_DIR)  dir_q <= pwdata & VM;
                end
            end

            gpio_sync2 #(.W(LANE)) u_sync (
                .clk (clk),
                .rst (rst),
                .d   (pin_in[p*LANE +: LANE] & VM),
                .q   (syn)
            );

            assign pin_out[p*LANE +: LANE] = dat_q;
            assign pin_oe[p*LANE +: LANE]  = dir_q;
            assign dat_rd[p] = dat_q;
            assign dir_rd[p] = dir_q;

            if (p == 0) begin : g_irq
                gpio_debounce #(.W(LANE)) u_db (
                    .clk  (clk),
                    .rst  (rst),
                    .tick (db_tick),
                    .en   (dben_q),
                    .d    (syn),
                    .q    (lvl_a)
                );
                assign ext_rd[p] = lvl_a;
            end else begin : g_plain
                assign ext_rd[p] = syn;
            end
        end else begin : g_off
            assign dat_rd[p] = '0;
            assign dir_rd[p] = '0;
            assign ext_rd[p] = '0;
        end
    end

    gpio_irq_unit #(.WIDTH(PORT_W[0])) u_irq (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl_a),
        .we       (wr_en),
        .kind     (sel.kind),
        .wdata    (pwdata),
        .en_o     (ien_w),
        .mask_o   (imask_w),
        .typ_o    (itype_w),
        .pol_o    (ipol_w),
        .status_o (istat_w),
        .irq_o    (irq)
    );

    assign irq_bits = istat_w;

    always_comb begin
        case (sel.kind)
            K_DATA:  rdata = dat_rd[sel.port];
            K_DIR:   rdata = dir_rd[sel.port];
            K_EXT:   rdata = ext_rd[sel.port];
            K_IEN:   rdata = ien_w;
            K_IMASK: rdata = imask_w;
            K_ITYPE: rdata = itype_w;
            K_IPOL:  rdata = ipol_w;
            K_ISTAT: rdata = istat_w;
            K_DBEN:  rdata = dben_q;
            default: rdata = '0;
        endcase
    end

    assign prdata = (psel && !pwrite) ? rdata : '0;
endmodule

// File: tb/tb_apb_gpio_top.sv
`timescale 1ns/1ps
module tb_apb_gpio_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, use_alt = 1'b0;
    logic [6:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic        db_tick = 1'b0;
    logic [127:0] pin_in = '0;
    logic [31:0] prdata_m, prdata_a, irqb_m, irqb_a;
    logic        rdy_m, rdy_a, irq_m, irq_a;
    logic [127:0] out_m, oe_m, out_a, oe_a;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    apb_gpio_top dut (
        .clk(clk), .rst(rst), .psel(psel && !use_alt), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_m), .pready(rdy_m), .db_tick(db_tick),
        .pin_in(pin_in), .pin_out(out_m), .pin_oe(oe_m), .irq_bits(irqb_m), .irq(irq_m));

    apb_gpio_top #(.ALT_MAP(1'b1)) dut_alt (
        .clk(clk), .rst(rst), .psel(psel && use_alt), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a), .pready(rdy_a), .db_tick(db_tick),
        .pin_in(pin_in), .pin_out(out_a), .pin_oe(oe_a), .irq_bits(irqb_a), .irq(irq_a));

    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cnt = (cnt + 1) % 8;
            db_tick = (cnt == 0);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apb_wr(input logic [6:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [6:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        @(negedge clk); penable = 1'b1;
        #1 d = use_alt ? prdata_a : prdata_m;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        apb_rd(7'h00, v); chk("R1 data reset", v, 0);
        apb_rd(7'h30, v); chk("R1 enable reset", v, 0);
        apb_rd(7'h40, v); chk("R1 status reset", v, 0);
        chk("R1 irq reset", {31'd0, irq_m}, 0);
        chk("R1 oe reset", oe_m[31:0], 0);
    endtask

    task automatic t_port_rw();
        logic [31:0] v, m;
        for (int p = 0; p < 4; p++) begin
            m = (p == 3) ? 32'h0F : 32'hFF;
            apb_wr(7'(p * 12), 32'hA5A5A5A5 ^ p);
            apb_wr(7'(p * 12 + 4), 32'hFFFFFFFF);
            apb_rd(7'(p * 12), v);
            chk("R2 data readback", v, (32'hA5A5A5A5 ^ p) & m);
            apb_rd(7'(p * 12 + 4), v);
            chk("R2 dir readback", v, m);
            chk("R2 pin_out", out_m[p*32 +: 32], (32'hA5A5A5A5 ^ p) & m);
            chk("R2 pin_oe", oe_m[p*32 +: 32], m);
        end
    endtask

    task automatic t_ext();
        logic [31:0] v;
        pin_in = {32'h0000000A, 32'h000000C3, 32'h12345678, 32'h00000081};
        idle(3);
        apb_rd(7'h50, v); chk("R3 ext A", v, 32'h81);
        apb_rd(7'h54, v); chk("R3 ext B", v, 32'h78);
        apb_rd(7'h5C, v); chk("R3 ext D width", v, 32'hA);
        pin_in[64 +: 32] = 32'h3C;
        apb_rd(7'h58, v); chk("R3 ext C two-flop latency old", v, 32'hC3);
        apb_rd(7'h58, v); chk("R3 ext C new", v, 32'h3C);
        apb_wr(7'h54, 32'hFFFFFFFF);
        apb_rd(7'h54, v); chk("R3 ext write ignored", v, 32'h78);
        pin_in = '0;
        idle(3);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        apb_wr(7'h38, 32'h3);
        apb_wr(7'h3C, 32'h1);
        apb_wr(7'h30, 32'h3);
        pin_in[0] = 1'b1; idle(4);
        chk("R4 rising latched", irqb_m, 32'h1);
        pin_in[0] = 1'b0; idle(4);
        chk("R4 rising held", irqb_m, 32'h1);
        apb_rd(7'h40, v); chk("R6 status", v, 32'h1);
        apb_wr(7'h4C, 32'h1); idle(1);
        chk("R8 clear", irqb_m, 32'h0);
        pin_in[1] = 1'b1; idle(4);
        chk("R4 falling ignores rise", irqb_m, 32'h0);
        pin_in[1] = 1'b0; idle(4);
        chk("R4 falling latched", irqb_m, 32'h2);
        chk("R6 combined irq", {31'd0, irq_m}, 1);
        apb_wr(7'h4C, 32'hFFFFFFFF); idle(1);
        chk("R8 clear all", {irqb_m[30:0], irq_m}, 0);
    endtask

    task automatic t_level();
        apb_wr(7'h3C, 32'h5);
        apb_wr(7'h30, 32'h4); idle(1);
        chk("R5 high idle", irqb_m, 0);
        pin_in[2] = 1'b1; idle(3);
        chk("R5 active high", irqb_m, 32'h4);
        pin_in[2] = 1'b0; idle(3);
        chk("R5 high released", irqb_m, 0);
        apb_wr(7'h30, 32'h8); idle(1);
        chk("R5 active low", irqb_m, 32'h8);
        pin_in[3] = 1'b1; idle(3);
        chk("R5 low released", irqb_m, 0);
        pin_in[3] = 1'b0;
        apb_wr(7'h30, 32'h0); idle(3);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        apb_wr(7'h30, 32'h1);
        pin_in[0] = 1'b1; idle(4);
        pin_in[0] = 1'b0;
        apb_wr(7'h34, 32'h1); idle(1);
        chk("R7 masked output", {irqb_m[30:0], irq_m}, 0);
        apb_rd(7'h40, v); chk("R6 masked status", v, 0);
        apb_wr(7'h34, 32'h0); idle(1);
        chk("R7 unmask reveals", irqb_m, 32'h1);
        apb_wr(7'h4C, 32'h1); idle(1);
    endtask

    task automatic t_enable();
        apb_wr(7'h30, 32'h0);
        pin_in[0] = 1'b1; idle(4);
        pin_in[0] = 1'b0; idle(4);
        apb_wr(7'h30, 32'h1); idle(1);
        chk("R9 no latch while disabled", irqb_m, 0);
    endtask

    task automatic t_eoi_race();
        logic [31:0] v;
        pin_in[0] = 1'b1; idle(4);
        pin_in[0] = 1'b0; idle(4);
        chk("R8 pending before race", irqb_m, 32'h1);
        pin_in[0] = 1'b1;
        @(negedge clk);
        apb_wr(7'h4C, 32'h1); idle(1);
        chk("R8 edge wins same-cycle clear", irqb_m, 32'h1);
        apb_wr(7'h4C, 32'h2); idle(1);
        chk("R8 zero bit no effect", irqb_m, 32'h1);
        apb_rd(7'h4C, v); chk("R8 clear reads zero", v, 0);
        apb_wr(7'h4C, 32'h1); idle(1);
        chk("R8 clear after race", irqb_m, 0);
        pin_in[0] = 1'b0; idle(4);
    endtask

    task automatic t_debounce();
        logic [31:0] v;
        int seen = 0;
        apb_wr(7'h38, 32'h2);
        apb_wr(7'h48, 32'h1);
        apb_rd(7'h48, v); chk("R10 debounce readback", v, 32'h1);
        idle(20);
        pin_in[0] = 1'b1; idle(2);
        pin_in[0] = 1'b0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (irqb_m[0]) seen++;
        end
        chk("R10 glitch filtered", seen, 0);
        apb_rd(7'h50, v); chk("R10 input reg filtered", v, 0);
        pin_in[0] = 1'b1; idle(30);
        chk("R10 stable accepted", irqb_m, 32'h1);
        apb_rd(7'h50, v); chk("R10 input reg accepted", v, 32'h1);
        pin_in[0] = 1'b0;
        apb_wr(7'h30, 32'h0);
        apb_wr(7'h48, 32'h0); idle(4);
    endtask

    task automatic t_alt();
        logic [31:0] v;
        use_alt = 1'b1;
        apb_wr(7'h44, 32'h5);
        apb_rd(7'h44, v); chk("R11 alt mask", v, 32'h5);
        apb_wr(7'h34, 32'h3);
        apb_rd(7'h34, v); chk("R11 alt type", v, 32'h3);
        apb_rd(7'h38, v); chk("R11 alt polarity", v, 32'h0);
        apb_rd(7'h4C, v); chk("R11 alt 0x4C unmapped", v, 32'h0);
        use_alt = 1'b0;
        apb_rd(7'h44, v); chk("R11 0x44 unmapped in normal map", v, 32'h0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_port_rw();
        t_ext();
        t_edge();
        t_level();
        t_mask();
        t_enable();
        t_eoi_race();
        t_debounce();
        t_alt();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule